// File: doc/BRIEF.md
# Alarm Zone FSK Transmitter Sequencer

This block is the digital sequencer for one transmitter in a wireless alarm zone. A single divider produces two tones and a slow bit clock. After power-up the block waits out an arming hold-off, so the installer has time to leave before any alarm can be sent. Once armed, it samples the detector contact on every bit clock. A trigger that holds raises a registered alarm flag. The flag turns off the power-on indicator. After a fixed settling delay, the block switches on the RF power stage.

While the alarm persists, transmission alternates between two phases of equal length. In the burst phase, a circular shift register sends a ten-bit frame serially. The frame holds a start bit, the strapped 7-bit zone address (least significant bit first), an even-parity bit and a stop bit. Each bit selects one of the two tones as the FSK modulating output. In the silent phase, the RF stage is off and the frame is reloaded, which gives other zones air time. When the contact opens, the block drops the alarm at the next bit clock.

Top module: `zone_tx_ctrl`

## Requirements
- R1: During and right after reset, `rf_en_o` is 0, `fsk_o` is 0 and `pwr_led_o` is 1.
- R2: For the first ARM_TICKS bit periods after reset, the detector input is ignored and `pwr_led_o` stays 1.
- R3: Once armed, `detect_i` is sampled on each bit-clock edge. `pwr_led_o` is 0 while the sampled alarm is active and 1 otherwise. `rf_en_o` is never 1 while `pwr_led_o` is 1.
- R4: `rf_en_o` rises exactly DLY_TICKS bit periods (DLY_TICKS*BIT_DIV clocks) after `pwr_led_o` falls.
- R5: Each burst starts with a ten-bit frame, one bit per BIT_DIV clocks, with the first bit beginning at the rise of `rf_en_o`. The bit order is: start bit 0, then address bits 0 to 6, then the even parity of the address (the XOR of its bits), then stop bit 1.
- R6: A frame bit of 1 puts tone f1 on `fsk_o`, a square wave toggling every F1_HALF clocks. A bit of 0 puts tone f2 on `fsk_o`, toggling every F2_HALF clocks.
- R7: While the alarm persists, `rf_en_o` is high for GATE_TICKS bit periods and then low for GATE_TICKS bit periods, and this repeats. Every burst restarts the frame from its start bit.
- R8: When `detect_i` goes low, `rf_en_o` falls and `pwr_led_o` rises at the next bit-clock edge. No burst follows.
- R9: `fsk_o` is 0 whenever `rf_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| detect_i | input | 1 | Detector contact, 1 = alarm condition |
| zone_addr_i | input | 7 | Strapped zone address |
| fsk_o | output | 1 | FSK modulating tone |
| rf_en_o | output | 1 | RF power stage enable |
| pwr_led_o | output | 1 | Power-on / idle indicator |

## Verification
The assertions assume that `zone_addr_i` is a static strap and that `detect_i` is a slow contact level held for at least one bit period. The bench sets the address only while the block is held in reset or idle. It changes `detect_i` only at falling clock edges and holds it for many bit periods. The properties relate the indicator, the RF enable and the tone output to each other and to the internal arming state. They therefore do not depend on how long the stimulus holds.

// File: rtl/zone_tx_pkg.sv
package zone_tx_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned FRAME_W = ADDR_W + 3;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // bit 0 leaves first: start, address LSB first, even parity, stop
  function automatic frame_t build_frame(input addr_t a);
    return {1'b1, ^a, a, 1'b0};
  endfunction
endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned BIT_DIV = 16,
  parameter int unsigned F1_HALF = 2,
  parameter int unsigned F2_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic f1_o,
  output logic f2_o
);
  localparam int unsigned BW  = $clog2(BIT_DIV + 1);
  localparam int unsigned F1W = $clog2(F1_HALF + 1);
  localparam int unsigned F2W = $clog2(F2_HALF + 1);

  logic [BW-1:0]  bit_cnt;
  logic [F1W-1:0] f1_cnt;
  logic [F2W-1:0] f2_cnt;

  assign tick_o = (bit_cnt == BW'(BIT_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_cnt <= '0;
    else if (tick_o) bit_cnt <= '0;
    else bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1_cnt <= '0;
      f1_o   <= 1'b0;
    end else if (f1_cnt == F1W'(F1_HALF - 1)) begin
      f1_cnt <= '0;
      f1_o   <= ~f1_o;
    end else begin
      f1_cnt <= f1_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f2_cnt <= '0;
      f2_o   <= 1'b0;
    end else if (f2_cnt == F2W'(F2_HALF - 1)) begin
      f2_cnt <= '0;
      f2_o   <= ~f2_o;
    end else begin
      f2_cnt <= f2_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/arm_timer.sv
module arm_timer #(
  parameter int unsigned ARM_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic armed_o
);
  localparam int unsigned AW = $clog2(ARM_TICKS + 1);

  logic [AW-1:0] cnt;

  assign armed_o = (cnt == AW'(ARM_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (tick_i && !armed_o) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gate_osc.sv
module gate_osc #(
  parameter int unsigned GATE_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic burst_o
);
  localparam int unsigned PERIOD = 2 * GATE_TICKS;
  localparam int unsigned GW     = $clog2(PERIOD + 1);

  logic [GW-1:0] cnt;

  assign burst_o = run_i && (cnt < GW'(GATE_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (tick_i) cnt <= (cnt == GW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import zone_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  logic   shift_i,
  input  frame_t data_i,
  output logic   bit_o
);
  frame_t sr;

  assign bit_o = sr[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else if (load_i) sr <= data_i;
    else if (shift_i) sr <= {sr[0], sr[FRAME_W-1:1]};
  end
endmodule

// File: rtl/zone_tx_ctrl.sv
module zone_tx_ctrl
  import zone_tx_pkg::*;
#(
  parameter int unsigned BIT_DIV    = 16,
  parameter int unsigned F1_HALF    = 2,
  parameter int unsigned F2_HALF    = 4,
  parameter int unsigned ARM_TICKS  = 4,
  parameter int unsigned DLY_TICKS  = 2,
  parameter int unsigned GATE_TICKS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       detect_i,
  input  logic [6:0] zone_addr_i,
  output logic       fsk_o,
  output logic       rf_en_o,
  output logic       pwr_led_o
);
  logic tick, f1, f2, armed, burst, tx_bit;
  logic trig_q, active;
  logic [DLY_TICKS-1:0] dly_sr;

  tone_divider #(.BIT_DIV(BIT_DIV), .F1_HALF(F1_HALF), .F2_HALF(F2_HALF)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .f1_o(f1), .f2_o(f2)
  );

  arm_timer #(.ARM_TICKS(ARM_TICKS)) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .armed_o(armed)
  );

  // detector capture on the bit clock, held off until armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else if (tick) trig_q <= detect_i & armed;
  end

  // settling delay from trigger to RF enable
  generate
    if (DLY_TICKS == 1) begin : g_dly1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_sr <= '0;
        else if (!trig_q) dly_sr <= '0;
        else if (tick) dly_sr <= 1'b1;
      end
    end else begin : g_dlyn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_sr <= '0;
        else if (!trig_q) dly_sr <= '0;
        else if (tick) dly_sr <= {dly_sr[DLY_TICKS-2:0], 1'b1};
      end
    end
  endgenerate

  assign active = trig_q & dly_sr[DLY_TICKS-1];

  gate_osc #(.GATE_TICKS(GATE_TICKS)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(active), .tick_i(tick), .burst_o(burst)
  );

  frame_shifter u_sr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(!burst), .shift_i(tick & burst),
    .data_i(build_frame(zone_addr_i)), .bit_o(tx_bit)
  );

  assign rf_en_o   = burst;
  assign fsk_o     = burst & (tx_bit ? f1 : f2);
  assign pwr_led_o = !trig_q;
endmodule

// File: rtl/zone_tx_chk.sv
module zone_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fsk_o,
  input logic rf_en_o,
  input logic pwr_led_o,
  input logic armed
);
  assert_quiet_tone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_en_o |-> !fsk_o);

  assert_rf_needs_alarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_en_o |-> !pwr_led_o);

  assert_holdoff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> pwr_led_o);

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_led_o) |-> !rf_en_o);

  assert_delay_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_en_o) |-> $past(!pwr_led_o));
endmodule

bind zone_tx_ctrl zone_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsk_o(fsk_o),
  .rf_en_o(rf_en_o), .pwr_led_o(pwr_led_o), .armed(armed)
);

// File: tb/sim_zone_tx_ctrl.sv
module sim_zone_tx_ctrl;
  localparam int BIT_DIV = 16, ARM = 4, DLY = 2, GATE = 10;

  logic clk = 1'b0, rst_n = 1'b0, detect = 1'b0;
  logic [6:0] addr = 7'h00;
  logic fsk, rf_en, pwr_led;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zone_tx_ctrl #(.BIT_DIV(BIT_DIV), .F1_HALF(2), .F2_HALF(4), .ARM_TICKS(ARM),
                 .DLY_TICKS(DLY), .GATE_TICKS(GATE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .detect_i(detect), .zone_addr_i(addr),
    .fsk_o(fsk), .rf_en_o(rf_en), .pwr_led_o(pwr_led)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit det, input logic [6:0] a);
    rst_n = 1'b0; detect = det; addr = a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rf(input bit lvl, input int lim, output int n);
    n = 0;
    while (rf_en !== lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  function automatic logic [9:0] exp_frame(input logic [6:0] a);
    return {1'b1, ^a, a, 1'b0};
  endfunction

  // called on first negedge with rf_en high; decodes ten bits
  task automatic decode(output logic [9:0] fr, output int t0, output int t9);
    for (int i = 0; i < 10; i++) begin
      logic prev;
      int tog;
      prev = fsk; tog = 0;
      for (int j = 1; j < BIT_DIV; j++) begin
        @(negedge clk);
        if (fsk !== prev) tog++;
        prev = fsk;
      end
      fr[i] = (tog >= 5);
      if (i == 0) t0 = tog;
      if (i == 9) t9 = tog;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0, 7'h00);
    chk(rf_en === 1'b0, "R1 rf_en", rf_en, 0);
    chk(fsk === 1'b0, "R1 fsk", fsk, 0);
    chk(pwr_led === 1'b1, "R1 pwr_led", pwr_led, 1);
  endtask

  task automatic t_arm_delay;
    int bad, n;
    do_reset(1'b1, 7'h5A);
    bad = 0;
    for (int k = 0; k < ARM * BIT_DIV - 4; k++) begin
      @(negedge clk);
      if (pwr_led !== 1'b1 || rf_en !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 holdoff", bad, 0);
    n = 0;
    while (pwr_led !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    chk(pwr_led === 1'b0, "R3 pwr_led low on alarm", pwr_led, 0);
    n = 0;
    while (rf_en !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(n == DLY * BIT_DIV, "R4 delay clocks", n, DLY * BIT_DIV);
  endtask

  task automatic t_frame(input logic [6:0] a);
    logic [9:0] fr;
    int n, t0, t9;
    do_reset(1'b1, a);
    wait_rf(1'b1, 400, n);
    decode(fr, t0, t9);
    chk(fr == exp_frame(a), "R5 frame", fr, exp_frame(a));
    chk(t0 >= 3 && t0 <= 4, "R6 f2 on bit 0", t0, 4);
    chk(t9 >= 7 && t9 <= 8, "R6 f1 on bit 1", t9, 8);
  endtask

  task automatic t_gating;
    int n, hi, lo, bad;
    logic [9:0] fr;
    int t0, t9;
    do_reset(1'b1, 7'h33);
    wait_rf(1'b1, 400, n);
    hi = 0;
    while (rf_en === 1'b1 && hi < 1000) begin @(negedge clk); hi++; end
    chk(hi == GATE * BIT_DIV, "R7 burst length", hi, GATE * BIT_DIV);
    lo = 0; bad = 0;
    while (rf_en === 1'b0 && lo < 1000) begin
      if (fsk !== 1'b0) bad++;
      @(negedge clk); lo++;
    end
    chk(lo == GATE * BIT_DIV, "R7 silent length", lo, GATE * BIT_DIV);
    chk(bad == 0, "R9 silent fsk", bad, 0);
    decode(fr, t0, t9);
    chk(fr == exp_frame(7'h33), "R7 second burst frame", fr, exp_frame(7'h33));
  endtask

  task automatic t_release;
    int n, bad;
    do_reset(1'b1, 7'h11);
    wait_rf(1'b1, 400, n);
    repeat (20) @(negedge clk);
    detect = 1'b0;
    n = 0;
    while (rf_en !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk(n <= BIT_DIV && pwr_led === 1'b1, "R8 release", n, BIT_DIV);
    bad = 0;
    for (int k = 0; k < 3 * GATE * BIT_DIV; k++) begin
      @(negedge clk);
      if (rf_en !== 1'b0 || fsk !== 1'b0 || pwr_led !== 1'b1) bad++;
    end
    chk(bad == 0, "R8 stays idle", bad, 0);
  endtask

  task automatic t_no_detect;
    int bad;
    do_reset(1'b0, 7'h7F);
    bad = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (rf_en !== 1'b0 || pwr_led !== 1'b1) bad++;
    end
    chk(bad == 0, "R3 idle without detect", bad, 0);
  endtask

  initial begin
    t_reset();
    t_arm_delay();
    t_frame(7'h5A);
    t_frame(7'h01);
    t_frame(7'h7F);
    t_gating();
    t_release();
    t_no_detect();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule